// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the low address bits for a four-beat burst. A strobe
loads a starting value for those bits. Each later cycle with the step
enable raised moves to the next beat. The caller joins the output with
the upper address bits, which it holds constant for the whole burst.

Two beat orders are supported, and the order is chosen when the burst is
loaded. In linear order each beat adds one to the field, modulo four. In
interleaved order each beat address is the starting value XOR a running
beat count. After four beats the field returns to the starting address
and keeps cycling for as long as stepping continues. A board pull-up on
the order input gives interleaved order when that input is left
undriven, so interleaved is also the order used after reset.

Top module: `burst_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `burst_addr` reads 0 after that edge, the beat count is zero and the held order is interleaved.
- R2: A clock edge with `load` high makes `burst_addr` equal to `start_addr` from the next cycle and clears the beat count to zero.
- R3: When `load` and `step_en` are both high at an edge, the load wins: `burst_addr` shows `start_addr` and no step is taken.
- R4: An edge with `load` low and `step_en` low leaves `burst_addr` unchanged.
- R5: If `order_sel` was 0 at the load, every step edge sets `burst_addr` to its previous value plus one, modulo 4 (for example 01, 10, 11, 00).
- R6: If `order_sel` was 1 at the load, `burst_addr` equals the start value XOR the beat count. This gives the sequences 00-01-10-11, 01-00-11-10, 10-11-00-01 and 11-10-01-00.
- R7: The fourth step after a load brings `burst_addr` back to the loaded start value, and stepping carries on in the same order.
- R8: `order_sel` is only sampled on load edges. Changing it in the middle of a burst has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Burst start strobe; captures `start_addr` and `order_sel` |
| start_addr | input | BW (2) | Starting value of the low address field |
| step_en | input | 1 | Move to the next beat when high and `load` is low |
| order_sel | input | 1 | Beat order sampled at load: 0 linear, 1 interleaved |
| burst_addr | output | BW (2) | Low address field for the current beat |

## Verification
The hardest case to reach from the ports is an order change in the middle
of a burst. After reset the interleaved and linear orders produce the same
sequence starting from 00, so that start value cannot tell them apart. The
stimulus therefore loads non-zero start values in both orders and toggles
`order_sel` while stepping. It also raises `load` and `step_en` together,
and steps past four beats so that the wrap is observed. A behavioural
model runs alongside the design and is compared with the output on every
cycle.

// File: rtl/bsq_pkg.sv
// Shared types for the burst address sequencer.
package bsq_pkg;
    // Beat order held for the duration of a burst.
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } bsq_order_e;
endpackage

// File: rtl/bsq_start_reg.sv
// Holds the burst start value and its beat order.
// Assumes: load is a single-cycle strobe; reset is synchronous and active low.
module bsq_start_reg
    import bsq_pkg::*;
#(
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [BW-1:0] start_addr,
    input  logic          order_sel,
    output logic [BW-1:0] base_q,
    output bsq_order_e    order_q
);
    // Capture the start value and the order on a load; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            order_q <= ORD_INTERLEAVE;
        end else if (load) begin
            base_q  <= start_addr;
            order_q <= order_sel ? ORD_INTERLEAVE : ORD_LINEAR;
        end
    end
endmodule

// File: rtl/bsq_beat_ctr.sv
// Counts the beats of a burst and wraps within BW bits.
// Assumes: load takes priority over step_en.
module bsq_beat_ctr #(
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step_en,
    output logic [BW-1:0] beat_q
);
    localparam logic [BW-1:0] ONE = BW'(1);

    // Clear on reset or load; otherwise advance by one when stepping.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            beat_q <= '0;
        end else if (step_en) begin
            beat_q <= beat_q + ONE;
        end
    end
endmodule

// File: rtl/bsq_addr_form.sv
// Forms the beat address from the start value and the beat count.
// Assumes: both inputs are registered, so this is a short combinational path.
module bsq_addr_form
    import bsq_pkg::*;
#(
    parameter int BW = 2
) (
    input  logic [BW-1:0] base_q,
    input  logic [BW-1:0] beat_q,
    input  bsq_order_e    order_q,
    output logic [BW-1:0] addr
);
    logic [BW-1:0] lin_addr;
    logic [BW-1:0] ilv_addr;

    // Interleaved order: each address bit flips with the matching count bit.
    for (genvar i = 0; i < BW; i++) begin : g_ilv
        assign ilv_addr[i] = base_q[i] ^ beat_q[i];
    end

    // Linear order: modulo add of the count to the start value.
    always_comb begin
        lin_addr = base_q + beat_q;
    end

    // Pick the order that was captured at load.
    always_comb begin
        addr = (order_q == ORD_INTERLEAVE) ? ilv_addr : lin_addr;
    end
endmodule

// File: rtl/burst_seq.sv
// Burst address sequencer top: start register, beat counter, address former.
// Assumes: the caller holds the upper address bits fixed for the burst.
module burst_seq
    import bsq_pkg::*;
#(
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [BW-1:0] start_addr,
    input  logic          step_en,
    input  logic          order_sel,
    output logic [BW-1:0] burst_addr
);
    logic [BW-1:0] base_q;
    logic [BW-1:0] beat_q;
    bsq_order_e    order_q;

    bsq_start_reg #(.BW(BW)) u_start (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .start_addr (start_addr),
        .order_sel  (order_sel),
        .base_q     (base_q),
        .order_q    (order_q)
    );

    bsq_beat_ctr #(.BW(BW)) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step_en (step_en),
        .beat_q  (beat_q)
    );

    bsq_addr_form #(.BW(BW)) u_form (
        .base_q  (base_q),
        .beat_q  (beat_q),
        .order_q (order_q),
        .addr    (burst_addr)
    );
endmodule

// File: rtl/bsq_checker.sv
// Property checks for burst_seq, attached to it with a bind statement.
// Assumes: order_q is the order held by the start register.
module bsq_checker
    import bsq_pkg::*;
#(
    parameter int BW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load,
    input logic [BW-1:0] start_addr,
    input logic          step_en,
    input logic [BW-1:0] burst_addr,
    input bsq_order_e    order_q
);
    // R1: a reset edge leaves the address at zero
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> burst_addr == '0);

    // R2, R3: a load shows the start value next cycle, even while stepping
    a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> burst_addr == $past(start_addr));

    // R4: no load and no step means no change
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step_en) |=> $stable(burst_addr));

    // R5: a linear step adds one modulo the field size
    a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step_en && order_q == ORD_LINEAR)
            |=> burst_addr == BW'($past(burst_addr) + BW'(1)));

    // R6: an interleaved step always flips the lowest address bit
    a_r6_ilv_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step_en && order_q == ORD_INTERLEAVE)
            |=> burst_addr[0] != $past(burst_addr[0]));

    // R8: the held order changes only on a load
    a_r8_order_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(order_q));
endmodule

bind burst_seq bsq_checker #(.BW(BW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .start_addr (start_addr),
    .step_en    (step_en),
    .burst_addr (burst_addr),
    .order_q    (order_q)
);

// File: tb/burst_seq_tb.sv
// Self-checking bench with a behavioural model compared every cycle.
module burst_seq_tb;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic [BW-1:0] start_addr = '0;
    logic          step_en = 1'b0;
    logic          order_sel = 1'b1;
    logic [BW-1:0] burst_addr;

    int checks = 0;
    int fails  = 0;

    // model state
    int m_base = 0;
    int m_cnt  = 0;
    int m_ilv  = 1;

    burst_seq #(.BW(BW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .start_addr (start_addr),
        .step_en    (step_en),
        .order_sel  (order_sel),
        .burst_addr (burst_addr)
    );

    always #5 clk = ~clk;

    function automatic int model_addr();
        if (m_ilv != 0) return m_base ^ m_cnt;
        return (m_base + m_cnt) % 4;
    endfunction

    task automatic check(input string tag);
        int exp_v;
        exp_v = model_addr();
        checks++;
        if (int'(burst_addr) != exp_v) begin
            fails++;
            $display("FAIL %s: burst_addr=%0d expected=%0d", tag, burst_addr, exp_v);
        end
    endtask

    // One clock: apply inputs, step the model at the edge, compare at the falling edge.
    task automatic cyc(input logic ld, input int sa, input logic st,
                       input logic os, input string tag);
        load       = ld;
        start_addr = BW'(sa);
        step_en    = st;
        order_sel  = os;
        @(posedge clk);
        if (!rst_n) begin
            m_base = 0; m_cnt = 0; m_ilv = 1;
        end else if (ld) begin
            m_base = sa; m_cnt = 0; m_ilv = os ? 1 : 0;
        end else if (st) begin
            m_cnt = (m_cnt + 1) % 4;
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(1'b1, 3, 1'b1, 1'b0, "R1 reset");
        cyc(1'b0, 0, 1'b0, 1'b0, "R1 reset");
        rst_n = 1'b1;
        cyc(1'b0, 0, 1'b0, 1'b1, "R4 hold after reset");

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                cyc(1'b1, s, 1'b0, m[0], "R2 load");
                for (int b = 0; b < 3; b++)
                    cyc(1'b0, 0, 1'b1, m[0], m != 0 ? "R6 interleaved step" : "R5 linear step");
                cyc(1'b0, 0, 1'b1, m[0], "R7 wrap to start");
                cyc(1'b0, 0, 1'b1, m[0], "R7 continue after wrap");
            end
        end

        cyc(1'b1, 2, 1'b0, 1'b1, "R2 load");
        cyc(1'b0, 0, 1'b1, 1'b1, "R6 interleaved step");
        cyc(1'b0, 0, 1'b0, 1'b1, "R4 hold");
        cyc(1'b0, 0, 1'b0, 1'b0, "R4 hold");
        cyc(1'b0, 0, 1'b1, 1'b1, "R6 interleaved step");

        cyc(1'b1, 1, 1'b1, 1'b0, "R3 load beats step");
        cyc(1'b1, 3, 1'b1, 1'b0, "R3 load beats step");
        cyc(1'b0, 0, 1'b1, 1'b0, "R5 linear step");

        cyc(1'b1, 1, 1'b0, 1'b1, "R2 load");
        cyc(1'b0, 0, 1'b1, 1'b0, "R8 order change ignored");
        cyc(1'b0, 0, 1'b1, 1'b0, "R8 order change ignored");
        cyc(1'b0, 0, 1'b1, 1'b1, "R8 order change ignored");
        cyc(1'b1, 1, 1'b0, 1'b0, "R2 load");
        cyc(1'b0, 0, 1'b1, 1'b1, "R8 order change ignored");
        cyc(1'b0, 0, 1'b1, 1'b1, "R8 order change ignored");

        rst_n = 1'b0;
        cyc(1'b0, 0, 1'b1, 1'b0, "R1 reset mid burst");
        rst_n = 1'b1;
        cyc(1'b0, 0, 1'b1, 1'b0, "R1 interleaved after reset");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule